// File: doc/BRIEF.md
# Sampling Converter Start, Search and Serial Readout Sequencer

This block is the digital control core of a small serial successive-approximation converter. A host raises a convert-start line to wake the core and begin tracking the input. When it drops the line, the sampler holds and the core runs a binary search over a 12-bit code, one trial bit per internal clock. The analog comparator and capacitive DAC sit outside the block. The core drives them through a trial-code output and reads back a single comparator decision. When the search ends, the core powers down again and presents the result MSB first on a serial data line. The host shifts the result out with its own serial clock, which may run up to 8 MHz.

No pin selects the input channel. The core remembers whether the host shifted out the whole previous result before the next start pulse. A complete read picks the first channel for the new conversion, and an incomplete read picks the second. The convert-start and serial-clock inputs are asynchronous. Each passes through a two-flop synchronizer into the internal clock domain before its edges are detected. The core flags a start pulse that was too short to acquire the input properly.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the core is powered down: pwr_down=1, busy=0, trk_en=0, cur_chan=0, sdo=0, acq_err=0, dac_code=0.
- R2: A rising edge of the synchronized cnv_start seen while powered down leaves power-down and enters track mode: trk_en=1, busy=1, pwr_down=0.
- R3: On that rising edge cur_chan becomes 1 (second channel) when fewer than 12 serial-clock rising edges arrived since the previous result was loaded. Otherwise it becomes 0 (first channel). Reset counts as a fully read result.
- R4: A falling edge of the synchronized cnv_start in track mode ends tracking and starts the search. The first trial code driven on dac_code is 0x800, with only the MSB set.
- R5: The search tests one bit per internal clock from MSB to LSB. A trial bit is kept when cmp_ge=1 (input at or above the trial level) and cleared when cmp_ge=0. With an ideal comparator the result equals the input code.
- R6: acq_err is set at the end of tracking when cnv_start stayed high for fewer than ACQ_CYCLES internal clocks. acq_err is clear when it stayed high for ACQ_CYCLES or more. It is cleared by the next accepted rising edge.
- R7: When the search completes, the core powers down by itself (busy=0, pwr_down=1) and sdo shows the result MSB.
- R8: sdo changes only on a synchronized falling edge of sclk or when a new result is loaded. Each falling edge advances one bit, MSB first. After the LSB, sdo holds the LSB until the next result is loaded.
- R9: A rising edge of cnv_start that arrives during the search is ignored: the search completes with the correct result and the core stays powered down afterwards.
- R10: dac_code is 0 whenever the core is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_start | input | 1 | Asynchronous convert-start line from the host |
| sclk | input | 1 | Asynchronous serial clock from the host |
| cmp_ge | input | 1 | Comparator decision: input is at or above the trial level |
| dac_code | output | RES_BITS | Trial code for the capacitive DAC, 0 when idle |
| trk_en | output | 1 | Sampler in track mode |
| cur_chan | output | 1 | Channel of the current conversion (0 first, 1 second) |
| sdo | output | 1 | Serial result data, MSB first |
| busy | output | 1 | Tracking or converting |
| pwr_down | output | 1 | Core is powered down |
| acq_err | output | 1 | Last start pulse was shorter than the acquisition window |

## Verification
The assertions assume that cnv_start and sclk are slow compared with clk: each level lasts at least a few internal clocks, so every edge survives the synchronizer as a single-cycle pulse. They also assume that cmp_ge answers the trial code within the same internal cycle. The bench drives both lines for whole multiples of the clock period, keeping every serial-clock phase at four cycles. It models the comparator as a combinational comparison of a chosen input code with dac_code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_SLEEP = 2'd0,
    SEQ_TRACK = 2'd1,
    SEQ_CONV  = 2'd2
  } seq_state_e;

  // Channel for the next conversion: second channel when the last result
  // was not fully shifted out.
  function automatic logic pick_chan(input logic fully_read);
    return !fully_read;
  endfunction
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         cmp_ge,
  output logic [W-1:0] trial,
  output logic         active,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int unsigned IW = $clog2(W);

  logic [W-1:0]  code_q;
  logic [IW-1:0] idx_q;

  // One search step: decide bit idx, then raise the next lower trial bit.
  function automatic logic [W-1:0] sar_step(input logic [W-1:0] code,
                                             input logic [IW-1:0] idx,
                                             input logic keep);
    logic [W-1:0] nxt;
    nxt = code;
    if (!keep) nxt[idx] = 1'b0;
    if (idx != '0) nxt[idx-1] = 1'b1;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
      active <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        code_q <= {1'b1, {(W-1){1'b0}}};
        idx_q  <= IW'(W-1);
        active <= 1'b1;
      end else if (active) begin
        code_q <= sar_step(code_q, idx_q, cmp_ge);
        if (idx_q == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
          result <= sar_step(code_q, idx_q, cmp_ge);
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign trial = active ? code_q : '0;
endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         sck_rise,
  input  logic         sck_fall,
  output logic         sdo,
  output logic         read_done
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] fall_cnt;
  logic [CW-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      fall_cnt <= '0;
      rise_cnt <= CW'(W);
    end else if (load) begin
      shreg    <= data;
      fall_cnt <= '0;
      rise_cnt <= '0;
    end else begin
      if (sck_rise && rise_cnt < CW'(W)) rise_cnt <= rise_cnt + 1'b1;
      if (sck_fall && fall_cnt < CW'(W-1)) begin
        shreg    <= {shreg[W-2:0], 1'b0};
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  assign sdo       = shreg[W-1];
  assign read_done = (rise_cnt == CW'(W));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_BITS    = 12,
  parameter int unsigned ACQ_CYCLES  = 350,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnv_start,
  input  logic                sclk,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] dac_code,
  output logic                trk_en,
  output logic                cur_chan,
  output logic                sdo,
  output logic                busy,
  output logic                pwr_down,
  output logic                acq_err
);
  localparam int unsigned AW = $clog2(ACQ_CYCLES + 1);

  seq_state_e          state;
  logic [AW-1:0]       acq_cnt;
  logic                start_lvl, start_rise, start_fall;
  logic                sck_lvl, sclk_rise, sclk_fall;
  logic                conv_go, sar_active, sar_done, res_load, read_done;
  logic [RES_BITS-1:0] sar_result;

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cnv_start),
    .level(start_lvl), .rise(start_rise), .fall(start_fall)
  );

  adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk),
    .level(sck_lvl), .rise(sclk_rise), .fall(sclk_fall)
  );

  assign conv_go  = (state == SEQ_TRACK) && start_fall;
  assign res_load = sar_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_SLEEP;
      acq_cnt  <= '0;
      cur_chan <= 1'b0;
      acq_err  <= 1'b0;
    end else begin
      unique case (state)
        SEQ_SLEEP: if (start_rise) begin
          state    <= SEQ_TRACK;
          acq_cnt  <= '0;
          acq_err  <= 1'b0;
          cur_chan <= pick_chan(read_done);
        end
        SEQ_TRACK: if (start_fall) begin
          state   <= SEQ_CONV;
          acq_err <= (acq_cnt < AW'(ACQ_CYCLES - 1));
        end else if (acq_cnt < AW'(ACQ_CYCLES)) begin
          acq_cnt <= acq_cnt + 1'b1;
        end
        SEQ_CONV: if (sar_done) state <= SEQ_SLEEP;
        default: state <= SEQ_SLEEP;
      endcase
    end
  end

  adc_sar_engine #(.W(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .go(conv_go), .cmp_ge(cmp_ge),
    .trial(dac_code), .active(sar_active), .done(sar_done),
    .result(sar_result)
  );

  adc_serial_out #(.W(RES_BITS)) u_sout (
    .clk(clk), .rst_n(rst_n), .load(res_load), .data(sar_result),
    .sck_rise(sclk_rise), .sck_fall(sclk_fall),
    .sdo(sdo), .read_done(read_done)
  );

  assign trk_en   = (state == SEQ_TRACK);
  assign busy     = (state != SEQ_SLEEP);
  assign pwr_down = (state == SEQ_SLEEP);
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_rise,
  input logic                sclk_fall,
  input logic                conv_go,
  input logic                sar_done,
  input logic                res_load,
  input logic                read_done,
  input logic [RES_BITS-1:0] dac_code,
  input logic                trk_en,
  input logic                cur_chan,
  input logic                sdo,
  input logic                busy,
  input logic                pwr_down
);
  assert_wake_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && pwr_down) |=> (trk_en && busy && !pwr_down));

  assert_chan_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && pwr_down) |=> (cur_chan == !$past(read_done)));

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> (dac_code == {1'b1, {(RES_BITS-1){1'b0}}}));

  assert_auto_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sar_done |=> (pwr_down && !busy));

  assert_sdo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !res_load) |=> $stable(sdo));

  assert_ignore_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trk_en && start_rise && !sar_done) |=> busy);

  assert_dac_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (dac_code == '0));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .sclk_fall(sclk_fall),
  .conv_go(conv_go), .sar_done(sar_done), .res_load(res_load),
  .read_done(read_done), .dac_code(dac_code), .trk_en(trk_en),
  .cur_chan(cur_chan), .sdo(sdo), .busy(busy), .pwr_down(pwr_down)
);

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;
  localparam int ACQ = 350;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnv_start = 1'b0;
  logic        sclk = 1'b0;
  logic        cmp_ge;
  logic [11:0] dac_code;
  logic        trk_en, cur_chan, sdo, busy, pwr_down, acq_err;
  logic [11:0] vin = '0;

  int nchecks = 0;
  int errors  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  // Ideal comparator: input at or above the trial level.
  assign cmp_ge = (vin >= dac_code);

  adc_conv_seq #(.RES_BITS(12), .ACQ_CYCLES(ACQ), .SYNC_STAGES(2)) u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .sclk(sclk),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .trk_en(trk_en),
    .cur_chan(cur_chan), .sdo(sdo), .busy(busy), .pwr_down(pwr_down),
    .acq_err(acq_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors  = errors + 1;
      nchecks = nchecks + 1;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, nchecks);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchecks = nchecks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One conversion; width of the start pulse is hold cycles.
  task automatic convert(input logic [11:0] v, input int hold,
                         input bit exp_chan, input bit inject);
    int n;
    vin = v;
    cnv_start = 1'b1;
    wait_cyc(6);
    check(trk_en && busy && !pwr_down, "R2 track after rise", {trk_en, busy, pwr_down}, 3'b110);
    check(cur_chan == exp_chan, "R3 channel pick", cur_chan, exp_chan);
    wait_cyc(hold - 6);
    cnv_start = 1'b0;
    n = 0;
    while (dac_code == '0 && n < 20) begin wait_cyc(1); n++; end
    check(dac_code == 12'h800, "R4 first trial", dac_code, 12'h800);
    if (inject) begin
      cnv_start = 1'b1;
      wait_cyc(3);
      cnv_start = 1'b0;
    end
    n = 0;
    while (busy && n < 40) begin wait_cyc(1); n++; end
    check(pwr_down && !busy, "R7 auto power-down", {pwr_down, busy}, 2'b10);
    check(sdo == v[11], "R7 MSB on sdo", sdo, v[11]);
    check(dac_code == '0, "R10 dac idle", dac_code, 0);
    check(acq_err == (hold < ACQ), "R6 acquisition flag", acq_err, (hold < ACQ));
  endtask

  // Shift out n bits; sdo sampled while sclk is low, before each rising edge.
  task automatic read_bits(input int n, input logic [11:0] v);
    for (int i = 0; i < n; i++) begin
      check(sdo == v[11-i], "R5/R8 serial bit", sdo, v[11-i]);
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
    end
  endtask

  initial begin
    logic [11:0] v;
    bit          exp_chan;
    wait_cyc(3);
    check(pwr_down && !busy && !trk_en, "R1 reset state", {pwr_down, busy, trk_en}, 3'b100);
    check(cur_chan == 0 && sdo == 0 && acq_err == 0 && dac_code == 0,
          "R1 reset outputs", {cur_chan, sdo, acq_err, dac_code}, 0);
    rst_n = 1'b1;
    wait_cyc(3);

    // Corner codes, full reads: first channel each time (R3, R5).
    convert(12'h000, ACQ, 1'b0, 1'b0); read_bits(12, 12'h000);
    convert(12'hFFF, ACQ, 1'b0, 1'b0); read_bits(12, 12'hFFF);
    convert(12'h800, ACQ, 1'b0, 1'b0); read_bits(12, 12'h800);
    convert(12'h7FF, ACQ, 1'b0, 1'b0); read_bits(12, 12'h7FF);
    // LSB held after the last bit (R8).
    sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
    check(sdo == 1'b1, "R8 LSB held", sdo, 1);
    convert(12'h001, ACQ, 1'b0, 1'b0); read_bits(12, 12'h001);
    sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
    check(sdo == 1'b1, "R8 LSB held after extra clocks", sdo, 1);

    // Sweep with alternating partial reads (R3, R5).
    exp_chan = 1'b0;
    for (int i = 0; i < 18; i++) begin
      v = 12'((i * 1237 + 5) % 4096);
      convert(v, ACQ + (i % 3), exp_chan, 1'b0);
      if (i % 2 == 1) begin
        read_bits(5, v);
        exp_chan = 1'b1;
      end else begin
        read_bits(12, v);
        exp_chan = 1'b0;
      end
    end

    // Acquisition window boundary (R6).
    convert(12'h5A5, ACQ - 1, exp_chan, 1'b0); read_bits(12, 12'h5A5);
    convert(12'hA5A, ACQ, 1'b0, 1'b0);         read_bits(12, 12'hA5A);
    convert(12'h3C3, 40, 1'b0, 1'b0);          read_bits(12, 12'h3C3);

    // Rise during conversion is ignored (R9).
    convert(12'h69C, ACQ, 1'b0, 1'b1);
    wait_cyc(10);
    check(pwr_down && !busy, "R9 stays powered down", {pwr_down, busy}, 2'b10);
    check(cur_chan == 1'b0, "R9 channel unchanged", cur_chan, 0);
    read_bits(12, 12'h69C);
    convert(12'h123, ACQ, 1'b0, 1'b0); read_bits(12, 12'h123);
    check(dac_code == '0, "R10 dac idle at end", dac_code, 0);

    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  end
endmodule